// File: doc/BRIEF.md
# Byte SPI Master with Two-Lane Write

This block is a byte-wide SPI master for a bus shared by several targets. A command arrives on a valid/ready handshake and carries a target index, a fast-write request, an optional transmit byte, a word size and an end-of-command flag. The block shifts the byte out and returns one received byte per normal transfer. It drives a serial clock, a data-out line and three active-low select pins.

Two shift modes exist. Normal mode moves one bit per serial clock and samples the data-in line on each rising edge. Fast-write mode moves two bits per serial clock. The upper bit of each pair rides on the data-out line and the lower bit rides on the third select pin, which serves as a second lane. A byte then takes four clocks instead of eight. Only one target index may use fast write. For any other target the request falls back to normal shifting.

Each half period of the serial clock lasts a programmable number of system clock cycles. Selects 0 and 1 are shared between targets: one target index owns select 0 and every other index uses select 1. Both selects are released once a command flagged as the last one completes.

Top module: `spim_dual_wr`

## Requirements
- R1: In normal mode a byte is sent most significant bit first on `spi_mosi` with exactly eight rising edges of `spi_sck`, and `spi_cs_n[2]` stays high for the whole transfer.
- R2: In fast-write mode (target index 1 with `cmd_fast`=1) a byte is sent as four bit pairs, most significant pair first, with exactly four `spi_sck` rising edges. Bits 7,5,3,1 appear on `spi_mosi` and bits 6,4,2,0 appear on `spi_cs_n[2]`, where a high level means 1.
- R3: Data and lane levels change only while `spi_sck` is low and are held stable while `spi_sck` is high, so targets sample on the rising edge.
- R4: A command whose `cmd_word_bits` is not 8 is consumed and rejected. `cmd_reject` pulses for one cycle, no `spi_sck` edge occurs, `busy` stays low and the select pins keep their levels.
- R5: When `cmd_has_tx`=0 the byte shifted out is 0x00, whatever `cmd_tx_byte` holds, and clocks still run.
- R6: A fast-write request to any target index other than 1 is carried out as a normal eight-clock transfer.
- R7: While a command to target index 2 is open, `spi_cs_n[0]` is low and `spi_cs_n[1]` is high. For every other index these levels are swapped. At most one of them is low at any time.
- R8: After a command with `cmd_last`=1 completes, `spi_cs_n[1:0]` returns to 2'b11. After a command with `cmd_last`=0 the select stays asserted. If a new command is accepted in the same cycle as a release, the new command's select wins.
- R9: In normal mode `rx_byte` holds the eight `spi_miso` samples taken at the rising edges, first sample as MSB. `rx_valid` pulses for exactly one cycle as the transfer ends. A fast-write transfer produces no `rx_valid`.
- R10: Each high and each low phase of `spi_sck` lasts `cfg_half_period` system clocks, with 0 treated as 1. `busy` is high from the cycle after acceptance until the last falling edge, which is 2*half*N cycles for N clocks. `cmd_ready` is low while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_period | input | 8 | System clocks per serial clock half period |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_target | input | 2 | Target index |
| cmd_fast | input | 1 | Request two-lane write |
| cmd_has_tx | input | 1 | Transmit byte supplied |
| cmd_tx_byte | input | 8 | Byte to send |
| cmd_word_bits | input | 4 | Requested word size; only 8 is accepted |
| cmd_last | input | 1 | Release selects after this byte |
| cmd_reject | output | 1 | One-cycle pulse for a refused word size |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is new |
| busy | output | 1 | Transfer in progress |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low selects; bit 2 doubles as the second write lane |

## Verification
Two functions can land on the same system clock edge. One is the select release that follows a completed last command. The other is the acceptance of the next command, which becomes possible in the very cycle `busy` drops. The bench holds a second command valid while the first is still shifting, so it is taken exactly on the release edge. It then checks that the selects show the new target rather than 2'b11 and that `busy` rises again. The end of `busy` and the `rx_valid` pulse also coincide, and the bench samples both on the same cycle.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/spim_phase_timer.sv
// Counts the system clocks of one serial clock half period.
module spim_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] half,
  output logic             expired
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (half == '0) ? '0 : half - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R10: an expired count never wraps unless reloaded
  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) == '0) |-> (cnt_q == '0));
endmodule

// File: rtl/spim_bit_engine.sv
// Serial clock phases, output shifting in one- or two-lane form, input capture.
module spim_bit_engine
  import spim_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 fast,
  input  logic [WORD_BITS-1:0] tx_byte,
  input  logic                 expired,
  input  logic                 miso,
  output logic                 load,
  output logic                 sck,
  output logic                 mosi,
  output logic                 lane2,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  localparam int CNT_W      = $clog2(WORD_BITS + 1);
  localparam int FAST_PAIRS = WORD_BITS / 2;

  phase_e               phase_q, phase_d;
  logic [CNT_W-1:0]     left_q, left_d;
  logic [WORD_BITS-1:0] sh_q, sh_d, rx_q, rx_d;
  logic                 sck_q, sck_d, mosi_q, mosi_d, lane_q, lane_d;
  logic                 fast_q, fast_d, done_q, done_d, rxv_q, rxv_d;

  always_comb begin
    phase_d = phase_q; left_d = left_q; sh_d = sh_q; rx_d = rx_q;
    sck_d = sck_q; mosi_d = mosi_q; lane_d = lane_q; fast_d = fast_q;
    done_d = 1'b0; rxv_d = 1'b0; load = 1'b0;
    case (phase_q)
      PH_IDLE: if (start) begin
        phase_d = PH_LOW;
        load    = 1'b1;
        fast_d  = fast;
        sck_d   = 1'b0;
        mosi_d  = tx_byte[WORD_BITS-1];
        if (fast) begin
          left_d = CNT_W'(FAST_PAIRS);
          lane_d = tx_byte[WORD_BITS-2];
          sh_d   = {tx_byte[WORD_BITS-3:0], 2'b00};
        end else begin
          left_d = CNT_W'(WORD_BITS);
          lane_d = 1'b1;
          sh_d   = {tx_byte[WORD_BITS-2:0], 1'b0};
        end
      end
      PH_LOW: if (expired) begin
        phase_d = PH_HIGH;
        load    = 1'b1;
        sck_d   = 1'b1;
        left_d  = left_q - 1'b1;
        if (!fast_q) rx_d = {rx_q[WORD_BITS-2:0], miso};
      end
      PH_HIGH: if (expired) begin
        sck_d = 1'b0;
        if (left_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          rxv_d   = !fast_q;
          lane_d  = 1'b1;
          mosi_d  = 1'b0;
        end else begin
          phase_d = PH_LOW;
          load    = 1'b1;
          mosi_d  = sh_q[WORD_BITS-1];
          if (fast_q) begin
            lane_d = sh_q[WORD_BITS-2];
            sh_d   = {sh_q[WORD_BITS-3:0], 2'b00};
          end else begin
            lane_d = 1'b1;
            sh_d   = {sh_q[WORD_BITS-2:0], 1'b0};
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE; left_q <= '0; sh_q <= '0; rx_q <= '0;
      sck_q <= 1'b0; mosi_q <= 1'b0; lane_q <= 1'b1; fast_q <= 1'b0;
      done_q <= 1'b0; rxv_q <= 1'b0;
    end else begin
      phase_q <= phase_d; left_q <= left_d; sh_q <= sh_d; rx_q <= rx_d;
      sck_q <= sck_d; mosi_q <= mosi_d; lane_q <= lane_d; fast_q <= fast_d;
      done_q <= done_d; rxv_q <= rxv_d;
    end
  end

  assign sck      = sck_q;
  assign mosi     = mosi_q;
  assign lane2    = lane_q;
  assign busy     = (phase_q != PH_IDLE);
  assign done     = done_q;
  assign rx_byte  = rx_q;
  assign rx_valid = rxv_q;

  // R3: levels held while the serial clock is high
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && $past(sck_q)) |-> ($stable(mosi_q) && $stable(lane_q)));
  // R9: received-byte strobe lasts one cycle
  a_r9_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxv_q |=> !rxv_q);
  // R1: second lane idles high during a single-lane transfer
  a_r1_lane_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fast_q) |-> lane_q);
endmodule

// File: rtl/spim_cs_select.sv
// Holds the shared selects 0 and 1 (active low) across a command.
module spim_cs_select #(
  parameter int TGT_W     = 2,
  parameter int FLASH_TGT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [TGT_W-1:0] target,
  input  logic             release_sel,
  output logic [1:0]       cs_n
);
  logic [1:0] cs_q, cs_d;

  always_comb begin
    cs_d = cs_q;
    if (accept) begin
      cs_d = (target == TGT_W'(FLASH_TGT)) ? 2'b10 : 2'b01;
    end else if (release_sel) begin
      cs_d = 2'b11;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 2'b11;
    else        cs_q <= cs_d;
  end

  assign cs_n = cs_q;

  // R7: never both shared selects active
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_q) <= 1);
  // R8: a release with no competing accept frees both selects
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (release_sel && !accept) |=> (cs_q == 2'b11));
endmodule

// File: rtl/spim_dual_wr.sv
module spim_dual_wr #(
  parameter int WORD_BITS = 8,
  parameter int DIV_W     = 8,
  parameter int TGT_W     = 2,
  parameter int FAST_TGT  = 1,
  parameter int FLASH_TGT = 2,
  parameter int WB_W      = $clog2(WORD_BITS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     cfg_half_period,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [TGT_W-1:0]     cmd_target,
  input  logic                 cmd_fast,
  input  logic                 cmd_has_tx,
  input  logic [WORD_BITS-1:0] cmd_tx_byte,
  input  logic [WB_W-1:0]      cmd_word_bits,
  input  logic                 cmd_last,
  output logic                 cmd_reject,
  output logic [WORD_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 busy,
  output logic                 spi_sck,
  output logic                 spi_mosi,
  input  logic                 spi_miso,
  output logic [2:0]           spi_cs_n
);
  logic [1:0] rst_q;
  logic       rst_sync_n;
  logic       accept, word_ok, start, fast_eff, load, expired, done, lane2;
  logic       last_q, last_d, rej_q, rej_d, eng_busy;
  logic [WORD_BITS-1:0] tx_eff;
  logic [1:0] cs_pair;

  // Reset asserts at once and leaves on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  assign cmd_ready = !eng_busy;
  assign accept    = cmd_valid && cmd_ready;
  assign word_ok   = (cmd_word_bits == WB_W'(WORD_BITS));
  assign start     = accept && word_ok;
  assign fast_eff  = cmd_fast && (cmd_target == TGT_W'(FAST_TGT));
  assign tx_eff    = cmd_has_tx ? cmd_tx_byte : '0;

  always_comb begin
    last_d = start ? cmd_last : last_q;
    rej_d  = accept && !word_ok;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      last_q <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      last_q <= last_d;
      rej_q  <= rej_d;
    end
  end

  spim_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .load(load),
    .half(cfg_half_period), .expired(expired)
  );

  spim_bit_engine #(.WORD_BITS(WORD_BITS)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .fast(fast_eff),
    .tx_byte(tx_eff), .expired(expired), .miso(spi_miso), .load(load),
    .sck(spi_sck), .mosi(spi_mosi), .lane2(lane2), .busy(eng_busy),
    .done(done), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  spim_cs_select #(.TGT_W(TGT_W), .FLASH_TGT(FLASH_TGT)) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .accept(start), .target(cmd_target),
    .release_sel(done && last_q), .cs_n(cs_pair)
  );

  assign busy       = eng_busy;
  assign cmd_reject = rej_q;
  assign spi_cs_n   = {lane2, cs_pair};

  // R4: a refused command never starts a transfer
  a_r4_reject_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_reject |-> !busy);
  // R10: the serial clock only toggles inside a busy window
  a_r10_sck_in_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spi_sck |-> busy);
endmodule

// File: tb/spim_dual_wr_bench.sv
module spim_dual_wr_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_half_period;
  logic       cmd_valid, cmd_ready, cmd_fast, cmd_has_tx, cmd_last, cmd_reject;
  logic [1:0] cmd_target;
  logic [7:0] cmd_tx_byte, rx_byte;
  logic [3:0] cmd_word_bits;
  logic       rx_valid, busy, spi_sck, spi_mosi, spi_miso;
  logic [2:0] spi_cs_n;

  always #4 clk = ~clk;

  spim_dual_wr u_spim_dual_wr (
    .clk(clk), .rst_n(rst_n), .cfg_half_period(cfg_half_period),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_target(cmd_target),
    .cmd_fast(cmd_fast), .cmd_has_tx(cmd_has_tx), .cmd_tx_byte(cmd_tx_byte),
    .cmd_word_bits(cmd_word_bits), .cmd_last(cmd_last), .cmd_reject(cmd_reject),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .busy(busy), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  typedef struct packed {
    logic [1:0] tgt;
    logic       fast;
    logic       has_tx;
    logic [7:0] tx;
    logic [7:0] miso;
    logic       last;
    logic [3:0] pulses;
    logic       rxv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b1, 8'hA5, 8'h3C, 1'b1, 4'd8, 1'b1},
    '{2'd1, 1'b1, 1'b1, 8'hB4, 8'h00, 1'b1, 4'd4, 1'b0},
    '{2'd2, 1'b0, 1'b1, 8'h81, 8'hC3, 1'b1, 4'd8, 1'b1},
    '{2'd2, 1'b1, 1'b1, 8'h5A, 8'hFF, 1'b1, 4'd8, 1'b1},
    '{2'd1, 1'b0, 1'b0, 8'h7E, 8'h96, 1'b1, 4'd8, 1'b1},
    '{2'd1, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b0, 4'd4, 1'b0},
    '{2'd1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 4'd4, 1'b0},
    '{2'd3, 1'b0, 1'b1, 8'h3C, 8'h5A, 1'b1, 4'd8, 1'b1}
  };

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // target model: shifts miso, records both write lanes on rising sck
  logic       arm = 1'b0;
  logic [7:0] arm_byte = 8'h00;
  logic [7:0] miso_sh, cap_mosi, cap_lane;
  logic [1:0] cap_cs;
  int         pulses;
  assign spi_miso = miso_sh[7];

  always @(posedge spi_sck or posedge arm) begin
    if (arm) begin
      miso_sh <= arm_byte; cap_mosi <= 8'h00; cap_lane <= 8'h00;
      cap_cs <= 2'b11; pulses <= 0;
    end else begin
      miso_sh  <= {miso_sh[6:0], 1'b0};
      cap_mosi <= {cap_mosi[6:0], spi_mosi};
      cap_lane <= {cap_lane[6:0], spi_cs_n[2]};
      if (pulses == 0) cap_cs <= spi_cs_n[1:0];
      pulses <= pulses + 1;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: cycles %0d expected completion before %0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mosi(input logic [7:0] b, input logic f);
    return f ? {4'h0, b[7], b[5], b[3], b[1]} : b;
  endfunction
  function automatic logic [7:0] exp_lane(input logic [7:0] b, input logic f);
    return f ? {4'h0, b[6], b[4], b[2], b[0]} : 8'hFF;
  endfunction

  int         busy_cyc, hi_min, hi_max, rxv_cnt, hi_run;
  logic [7:0] rx_seen;
  logic       ready_mid;

  task automatic run(input logic [1:0] tgt, input logic f, input logic has,
                     input logic [7:0] tx, input logic [7:0] mb, input logic last);
    @(negedge clk);
    arm_byte = mb; arm = 1'b1; #1 arm = 1'b0;
    cmd_target = tgt; cmd_fast = f; cmd_has_tx = has; cmd_tx_byte = tx;
    cmd_last = last; cmd_word_bits = 4'd8; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    ready_mid = cmd_ready;
    busy_cyc = 0; hi_min = 999; hi_max = 0; rxv_cnt = 0; hi_run = 0; rx_seen = 8'h00;
    forever begin
      if (rx_valid) begin rxv_cnt++; rx_seen = rx_byte; end
      if (spi_sck) hi_run++;
      else if (hi_run != 0) begin
        if (hi_run < hi_min) hi_min = hi_run;
        if (hi_run > hi_max) hi_max = hi_run;
        hi_run = 0;
      end
      if (!busy) break;
      busy_cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    if (rx_valid) rxv_cnt++;
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_target = 2'd0; cmd_fast = 1'b0;
    cmd_has_tx = 1'b0; cmd_tx_byte = 8'h00; cmd_word_bits = 4'd8; cmd_last = 1'b0;
    cfg_half_period = 8'd2;
    arm = 1'b1; #1 arm = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R7 reset selects", {29'd0, spi_cs_n}, 32'h7);
    check("R10 reset busy/ready", {30'd0, busy, cmd_ready}, 32'h1);
    check("R1 reset sck", {31'd0, spi_sck}, 32'h0);
    check("R9 reset rx_valid", {31'd0, rx_valid}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic ef;
      logic [7:0] txe;
      logic [1:0] sel_exp;
      ef = VECS[i].fast && (VECS[i].tgt == 2'd1);
      txe = VECS[i].has_tx ? VECS[i].tx : 8'h00;
      sel_exp = (VECS[i].tgt == 2'd2) ? 2'b10 : 2'b01;
      run(VECS[i].tgt, VECS[i].fast, VECS[i].has_tx, VECS[i].tx, VECS[i].miso, VECS[i].last);
      check(ef ? "R2 pulse count" : "R1 R6 pulse count", pulses, {28'd0, VECS[i].pulses});
      check(ef ? "R2 data lane" : "R1 R5 data lane", {24'd0, cap_mosi}, {24'd0, exp_mosi(txe, ef)});
      check(ef ? "R2 second lane" : "R1 second lane idle", {24'd0, cap_lane}, {24'd0, exp_lane(txe, ef)});
      check("R7 select during transfer", {30'd0, cap_cs}, {30'd0, sel_exp});
      check("R8 select after command", {30'd0, spi_cs_n[1:0]},
            {30'd0, VECS[i].last ? 2'b11 : sel_exp});
      check("R9 rx_valid pulses", rxv_cnt, {31'd0, VECS[i].rxv});
      if (VECS[i].rxv) check("R9 received byte", {24'd0, rx_seen}, {24'd0, VECS[i].miso});
      check("R10 busy length", busy_cyc, 2 * 2 * VECS[i].pulses);
      check("R3 R10 high phase", hi_max, 2);
    end

    // R10: half period 1 and 5, ready low mid transfer
    cfg_half_period = 8'd1;
    run(2'd0, 1'b0, 1'b1, 8'h69, 8'h0F, 1'b1);
    check("R10 busy length half=1", busy_cyc, 16);
    check("R10 high phase half=1", hi_min, 1);
    check("R10 ready low while busy", {31'd0, ready_mid}, 32'h0);
    cfg_half_period = 8'd5;
    run(2'd1, 1'b1, 1'b1, 8'hC6, 8'h00, 1'b1);
    check("R10 busy length half=5", busy_cyc, 40);
    check("R10 high phase half=5 min", hi_min, 5);
    check("R10 high phase half=5 max", hi_max, 5);
    check("R2 data lane half=5", {24'd0, cap_mosi}, {24'd0, exp_mosi(8'hC6, 1'b1)});
    cfg_half_period = 8'd2;

    // R4: refused word size leaves an open select untouched
    run(2'd2, 1'b0, 1'b1, 8'h11, 8'h22, 1'b0);
    @(negedge clk);
    arm = 1'b1; #1 arm = 1'b0;
    cmd_target = 2'd1; cmd_word_bits = 4'd7; cmd_last = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word_bits = 4'd8;
    check("R4 reject pulse", {31'd0, cmd_reject}, 32'h1);
    check("R4 busy stays low", {31'd0, busy}, 32'h0);
    @(negedge clk);
    check("R4 reject one cycle", {31'd0, cmd_reject}, 32'h0);
    repeat (10) @(negedge clk);
    check("R4 no serial clocks", pulses, 0);
    check("R4 select unchanged", {30'd0, spi_cs_n[1:0]}, 32'h2);
    run(2'd2, 1'b0, 1'b1, 8'h33, 8'h44, 1'b1);
    check("R8 released after last", {30'd0, spi_cs_n[1:0]}, 32'h3);

    // R8: accept lands on the release edge
    @(negedge clk);
    arm = 1'b1; #1 arm = 1'b0;
    cmd_target = 2'd0; cmd_fast = 1'b0; cmd_has_tx = 1'b1; cmd_tx_byte = 8'h55;
    cmd_last = 1'b1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_target = 2'd2; cmd_tx_byte = 8'hAA;
    while (busy) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R8 new command wins release edge", {30'd0, spi_cs_n[1:0]}, 32'h2);
    check("R10 back-to-back busy", {31'd0, busy}, 32'h1);
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R8 final release", {30'd0, spi_cs_n[1:0]}, 32'h3);

    summary();
    $finish;
  end
endmodule